// File: doc/BRIEF.md
# Range-Matched Fully Associative Translation Buffer

This block is a small fully associative address translation buffer. Each slot keeps an inclusive virtual range (a first and a last address), the physical base of one page, and a protection word. A lookup port compares a virtual address against every slot at once. Within the same cycle it returns the first slot whose range contains the address, the physical address (the page base with the page offset added), the protection word and a validity flag.

Software fills a slot in two steps. An address insert claims a slot and records the range and the physical page. The slot stays invalid until a protection insert to an address inside that range loads the protection fields and marks it valid. A single-page purge and a purge-all remove translations. When an address insert finds no free slot, a rotating pointer picks the slot to evict.

Every command is sampled on a rising clock edge and changes the table at that edge. The lookup is purely combinational.

Top module: `rt_tlb`

## Requirements
- R1: After reset every slot is zeroed and invalid, the eviction pointer is 0, and `prot_err_o` is low. A lookup of any nonzero address reports no hit.
- R2: A slot matches when first <= address <= last, with both ends inclusive. When several slots match, the one with the lowest index wins. On a hit, `lk_pa_o` is the stored page base plus address bits 11..0, and `lk_prot_o` shows the stored protection fields at their insert bit positions with all other bits 0. On a miss, every lookup output is 0.
- R3: An address insert writes the following into the chosen slot: first = address with bits 11..0 cleared, last = first + 0xFFF, page base = `cmd_data_i[24:5]` shifted left by 12. The protection fields are zero and the slot is invalid.
- R4: An address insert zeroes every valid slot whose range contains the command address.
- R5: An address insert uses the lowest-index slot that is invalid or contains the address. If there is none, it uses the slot at the eviction pointer. The pointer then advances by one and wraps from 15 to 0. The pointer moves at no other time.
- R6: A protection insert updates the first slot whose range contains the address, whether or not that slot is valid. It loads access id = bits 18..1, user bit = 19, write level = 21..20, read level = 23..22, rights type = 26..24, break bit = 27, dirty bit = 28, trap bit = 29, and sets the slot valid.
- R7: A protection insert that matches no slot changes nothing. `prot_err_o` is high for exactly the following cycle.
- R8: A single-page purge zeroes the first slot containing the address, but only if that slot is valid. If the slot is invalid, it is left untouched.
- R9: A purge-all zeroes every slot and leaves the eviction pointer unchanged.
- R10: When several commands are asserted in the same cycle, only one takes effect, in this order of priority: purge-all, then address insert, then protection insert, then single-page purge.
- R11: A zeroed slot covers only address 0. A lookup of address 0 against such a slot reports a hit with `lk_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_va_i | input | 1 | Address insert command |
| ins_prot_i | input | 1 | Protection insert command |
| purge_i | input | 1 | Single-page purge command |
| purge_all_i | input | 1 | Purge-all command |
| cmd_va_i | input | 32 | Virtual address used by the commands |
| cmd_data_i | input | 32 | Page field (address insert) or protection word (protection insert) |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Some slot's range contains the lookup address |
| lk_vld_o | output | 1 | The matching slot is valid |
| lk_pa_o | output | 32 | Translated physical address |
| lk_prot_o | output | 32 | Protection word of the matching slot |
| prot_err_o | output | 1 | Previous cycle's protection insert found no slot |

## Verification
A corrupted slot, a wrong victim choice or a pointer that drifts shows at the lookup port as soon as the affected address is probed. The bench probes an address on every cycle, so an error in table state surfaces within one lookup of that page. A stale eviction pointer stays hidden until the table is full. It then moves translations to the wrong slot, which shows up later as lost hits or as the wrong slot winning the lowest-index match. The error flag is compared one cycle after each protection insert.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_W   = 12;
    localparam int PPN_W  = 20;
    localparam int PPN_LO = 5;
    localparam int AID_W  = 18;

    typedef struct packed {
        logic [VA_W-1:0]  va_lo;
        logic [VA_W-1:0]  va_hi;
        logic [VA_W-1:0]  pa;
        logic [AID_W-1:0] aid;
        logic             usr;
        logic [1:0]       wr_lvl;
        logic [1:0]       rd_lvl;
        logic [2:0]       rtype;
        logic             brk;
        logic             dirty;
        logic             trap;
        logic             vld;
    } ent_t;

    typedef enum logic [2:0] {OP_NONE, OP_WIPE, OP_INS_VA, OP_INS_PROT, OP_PURGE} op_e;

    function automatic op_e pick_op(logic wipe, logic ins_va, logic ins_prot, logic purge);
        if (wipe)          return OP_WIPE;
        else if (ins_va)   return OP_INS_VA;
        else if (ins_prot) return OP_INS_PROT;
        else if (purge)    return OP_PURGE;
        return OP_NONE;
    endfunction

    function automatic ent_t load_prot(ent_t e, logic [31:0] w);
        ent_t r = e;
        r.aid    = w[18:1];
        r.usr    = w[19];
        r.wr_lvl = w[21:20];
        r.rd_lvl = w[23:22];
        r.rtype  = w[26:24];
        r.brk    = w[27];
        r.dirty  = w[28];
        r.trap   = w[29];
        r.vld    = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] show_prot(ent_t e);
        logic [31:0] w = '0;
        w[18:1]  = e.aid;
        w[19]    = e.usr;
        w[21:20] = e.wr_lvl;
        w[23:22] = e.rd_lvl;
        w[26:24] = e.rtype;
        w[27]    = e.brk;
        w[28]    = e.dirty;
        w[29]    = e.trap;
        return w;
    endfunction
endpackage

// File: rtl/tlb_range_cmp.sv
module tlb_range_cmp #(
    parameter int NENT = 16
) (
    input  tlb_pkg::ent_t               tab_i [NENT],
    input  logic [tlb_pkg::VA_W-1:0]    va_i,
    output logic [NENT-1:0]             cov_o
);
    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        assign cov_o[g] = (tab_i[g].va_lo <= va_i) && (va_i <= tab_i[g].va_hi);
    end
endmodule

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rt_tlb.sv
module rt_tlb #(
    parameter int NENT = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ins_va_i,
    input  logic        ins_prot_i,
    input  logic        purge_i,
    input  logic        purge_all_i,
    input  logic [31:0] cmd_va_i,
    input  logic [31:0] cmd_data_i,
    input  logic [31:0] lk_va_i,
    output logic        lk_hit_o,
    output logic        lk_vld_o,
    output logic [31:0] lk_pa_o,
    output logic [31:0] lk_prot_o,
    output logic        prot_err_o
);
    import tlb_pkg::*;

    localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
    localparam logic [VA_W-1:0] PG_MASK = VA_W'((64'd1 << PG_W) - 1);

    ent_t          tab [NENT];
    ent_t          nxt [NENT];
    logic [IW-1:0] rot_q, rot_d;
    logic          err_q, err_d;
    logic [NENT-1:0] vld_v, cmd_cov, lk_cov;
    logic          cmd_found, lk_found, slot_found;
    logic [IW-1:0] cmd_idx, lk_idx, slot_idx, tgt;
    op_e           op;
    ent_t          sel;

    for (genvar g = 0; g < NENT; g++) begin : g_vld
        assign vld_v[g] = tab[g].vld;
    end

    tlb_range_cmp #(.NENT(NENT)) u_cmd_cmp (.tab_i(tab), .va_i(cmd_va_i), .cov_o(cmd_cov));
    tlb_range_cmp #(.NENT(NENT)) u_lk_cmp  (.tab_i(tab), .va_i(lk_va_i),  .cov_o(lk_cov));

    tlb_first_one #(.N(NENT)) u_cmd_ff  (.req_i(cmd_cov),          .found_o(cmd_found),  .idx_o(cmd_idx));
    tlb_first_one #(.N(NENT)) u_lk_ff   (.req_i(lk_cov),           .found_o(lk_found),   .idx_o(lk_idx));
    tlb_first_one #(.N(NENT)) u_slot_ff (.req_i(cmd_cov | ~vld_v), .found_o(slot_found), .idx_o(slot_idx));

    assign op  = pick_op(purge_all_i, ins_va_i, ins_prot_i, purge_i);
    assign tgt = slot_found ? slot_idx : rot_q;

    always_comb begin
        for (int i = 0; i < NENT; i++) nxt[i] = tab[i];
        rot_d = rot_q;
        err_d = 1'b0;
        case (op)
            OP_WIPE: begin
                for (int i = 0; i < NENT; i++) nxt[i] = '0;
            end
            OP_INS_VA: begin
                for (int i = 0; i < NENT; i++)
                    if (cmd_cov[i] && tab[i].vld) nxt[i] = '0;
                if (!slot_found)
                    rot_d = (rot_q == IW'(NENT - 1)) ? '0 : rot_q + 1'b1;
                nxt[tgt]       = '0;
                nxt[tgt].va_lo = cmd_va_i & ~PG_MASK;
                nxt[tgt].va_hi = (cmd_va_i & ~PG_MASK) | PG_MASK;
                nxt[tgt].pa    = VA_W'({cmd_data_i[PPN_LO +: PPN_W], {PG_W{1'b0}}});
            end
            OP_INS_PROT: begin
                if (cmd_found) nxt[cmd_idx] = load_prot(tab[cmd_idx], cmd_data_i);
                else           err_d = 1'b1;
            end
            OP_PURGE: begin
                if (cmd_found && tab[cmd_idx].vld) nxt[cmd_idx] = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) tab[i] <= '0;
            rot_q <= '0;
            err_q <= 1'b0;
        end else begin
            for (int i = 0; i < NENT; i++) tab[i] <= nxt[i];
            rot_q <= rot_d;
            err_q <= err_d;
        end
    end

    assign sel        = tab[lk_idx];
    assign lk_hit_o   = lk_found;
    assign lk_vld_o   = lk_found && sel.vld;
    assign lk_pa_o    = lk_found ? (sel.pa | (lk_va_i & PG_MASK)) : '0;
    assign lk_prot_o  = lk_found ? show_prot(sel) : '0;
    assign prot_err_o = err_q;

    // R5: the pointer only moves after an insert that found every slot valid
    p_rot_only_evict_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(rot_q) |-> $past(ins_va_i && !purge_all_i && (&vld_v)));

    // R7: error flag only follows a protection insert that won priority
    p_err_after_prot_r7: assert property (@(posedge clk) disable iff (rst)
        prot_err_o |-> $past(ins_prot_i && !ins_va_i && !purge_all_i));

    // R9: nothing valid remains after a purge-all
    p_wipe_clears_r9: assert property (@(posedge clk) disable iff (rst)
        $past(purge_all_i) |-> (vld_v == '0));

    // R4: an address insert never adds a valid slot
    p_va_ins_no_grow_r4: assert property (@(posedge clk) disable iff (rst)
        $past(ins_va_i && !purge_all_i) |-> ($countones(vld_v) <= $past($countones(vld_v))));

    // R2: page offset passes through on a hit
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit_o |-> (lk_pa_o[PG_W-1:0] == lk_va_i[PG_W-1:0]));

    // R2: a valid report implies a hit
    p_vld_needs_hit_r2: assert property (@(posedge clk) disable iff (rst)
        lk_vld_o |-> lk_hit_o);
endmodule

// File: tb/rt_tlb_test.sv
`timescale 1ns/1ps
module rt_tlb_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_va = 1'b0, ins_prot = 1'b0, purge = 1'b0, purge_all = 1'b0;
    logic [31:0] cmd_va = '0, cmd_data = '0, lk_va = '0;
    logic        lk_hit, lk_vld, prot_err;
    logic [31:0] lk_pa, lk_prot;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_lo [16];
    logic [31:0] m_hi [16];
    logic [31:0] m_pa [16];
    logic [31:0] m_pw [16];
    bit          m_v  [16];
    int          m_ptr = 0;
    bit          m_err = 1'b0;

    always #2.5 clk = ~clk;

    rt_tlb uut (
        .clk(clk), .rst(rst),
        .ins_va_i(ins_va), .ins_prot_i(ins_prot), .purge_i(purge), .purge_all_i(purge_all),
        .cmd_va_i(cmd_va), .cmd_data_i(cmd_data), .lk_va_i(lk_va),
        .lk_hit_o(lk_hit), .lk_vld_o(lk_vld), .lk_pa_o(lk_pa), .lk_prot_o(lk_prot),
        .prot_err_o(prot_err)
    );

    function automatic int m_find(logic [31:0] a);
        for (int i = 0; i < 16; i++)
            if (m_lo[i] <= a && a <= m_hi[i]) return i;
        return -1;
    endfunction

    function automatic void m_zero(int i);
        m_lo[i] = '0; m_hi[i] = '0; m_pa[i] = '0; m_pw[i] = '0; m_v[i] = 1'b0;
    endfunction

    function automatic void m_apply(bit a_ins, bit a_prot, bit a_pg, bit a_all,
                                    logic [31:0] va, logic [31:0] d);
        int k;
        int sel;
        m_err = 1'b0;
        if (a_all) begin
            for (int i = 0; i < 16; i++) m_zero(i);
        end else if (a_ins) begin
            sel = -1;
            for (int i = 0; i < 16; i++)
                if (sel < 0 && (!m_v[i] || (m_lo[i] <= va && va <= m_hi[i]))) sel = i;
            for (int i = 0; i < 16; i++)
                if (m_v[i] && m_lo[i] <= va && va <= m_hi[i]) m_zero(i);
            if (sel < 0) begin
                sel = m_ptr;
                m_ptr = (m_ptr + 1) % 16;
            end
            m_zero(sel);
            m_lo[sel] = {va[31:12], 12'h000};
            m_hi[sel] = {va[31:12], 12'hFFF};
            m_pa[sel] = {d[24:5], 12'h000};
        end else if (a_prot) begin
            k = m_find(va);
            if (k < 0) m_err = 1'b1;
            else begin
                m_pw[k] = d & 32'h3FFF_FFFE;
                m_v[k]  = 1'b1;
            end
        end else if (a_pg) begin
            k = m_find(va);
            if (k >= 0 && m_v[k]) m_zero(k);
        end
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (lk_va=%h)", tag, what, act, exp, lk_va);
        end
    endtask

    task automatic step(bit a_ins, bit a_prot, bit a_pg, bit a_all,
                        logic [31:0] va, logic [31:0] d, logic [31:0] la, string tag);
        int k;
        @(negedge clk);
        ins_va = a_ins; ins_prot = a_prot; purge = a_pg; purge_all = a_all;
        cmd_va = va; cmd_data = d; lk_va = la;
        #1;
        k = m_find(la);
        chk(tag, "hit",  {31'b0, lk_hit}, {31'b0, k >= 0});
        chk(tag, "vld",  {31'b0, lk_vld}, {31'b0, (k >= 0) ? m_v[k] : 1'b0});
        chk(tag, "pa",   lk_pa,   (k >= 0) ? (m_pa[k] | {20'b0, la[11:0]}) : 32'h0);
        chk(tag, "prot", lk_prot, (k >= 0) ? m_pw[k] : 32'h0);
        chk(tag, "err",  {31'b0, prot_err}, {31'b0, m_err});
        m_apply(a_ins, a_prot, a_pg, a_all, va, d);
    endtask

    task automatic idle(logic [31:0] la, string tag);
        step(0, 0, 0, 0, '0, '0, la, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_zero(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state; R11 zeroed slots cover address 0
        idle(32'h0000_1234, "R1");
        idle(32'hFFFF_FFFF, "R1");
        idle(32'h0000_0000, "R11");

        // R3 address insert, slot stays invalid
        step(1, 0, 0, 0, 32'h0040_1ABC, 32'h12345 << 5, 32'h0040_1ABC, "R3");
        idle(32'h0040_1ABC, "R3");
        // R6 protection insert sets fields and valid
        step(0, 1, 0, 0, 32'h0040_1FFF, 32'h3FFF_FFFF, 32'h0040_1000, "R6");
        idle(32'h0040_1000, "R6");
        // R2 inclusive boundaries
        idle(32'h0040_1FFF, "R2");
        idle(32'h0040_2000, "R2");
        idle(32'h0040_0FFF, "R2");
        step(0, 1, 0, 0, 32'h0040_1000, 32'h1555_5552, 32'h0040_1800, "R6");
        idle(32'h0040_1800, "R6");

        // R7 protection insert without a slot: one-cycle error, no change
        step(0, 1, 0, 0, 32'h0777_7000, 32'h2000_0000, 32'h0777_7000, "R7");
        idle(32'h0040_1000, "R7");
        idle(32'h0777_7000, "R7");

        // R4 overlapping address insert zeroes the valid slot and reuses it
        step(1, 0, 0, 0, 32'h0040_1500, 32'h000AB << 5, 32'h0040_1500, "R4");
        idle(32'h0040_1500, "R4");
        step(0, 1, 0, 0, 32'h0040_1500, 32'h1000_0002, 32'h0040_1500, "R4");
        idle(32'h0040_1500, "R4");

        // R8 purge of a valid slot, then of an invalid one
        step(0, 0, 1, 0, 32'h0040_1234, 32'h0, 32'h0040_1234, "R8");
        idle(32'h0040_1234, "R8");
        step(1, 0, 0, 0, 32'h0050_0000, 32'h000CD << 5, 32'h0050_0000, "R8");
        step(0, 0, 1, 0, 32'h0050_0010, 32'h0, 32'h0050_0010, "R8");
        idle(32'h0050_0010, "R8");

        // R5 fill all slots, then evict past the wrap
        step(0, 0, 0, 1, 32'h0, 32'h0, 32'h0050_0010, "R9");
        for (int i = 0; i < 36; i++) begin
            step(1, 0, 0, 0, 32'h0100_0000 + (i << 12), (i + 7) << 5, 32'h0100_0000 + (i << 12), "R5");
            step(0, 1, 0, 0, 32'h0100_0000 + (i << 12), 32'h1000_0000 | i << 1, 32'h0100_0000 + ((i % 17) << 12), "R5");
        end
        for (int i = 0; i < 36; i++) idle(32'h0100_0000 + (i << 12) + 12'h0FF, "R5");

        // R9 purge-all keeps the pointer; refill and evict again
        step(0, 0, 0, 1, 32'h0, 32'h0, 32'h0100_3000, "R9");
        idle(32'h0100_3000, "R9");
        for (int i = 0; i < 20; i++) begin
            step(1, 0, 0, 0, 32'h0200_0000 + (i << 12), i << 5, 32'h0200_0000, "R9");
            step(0, 1, 0, 0, 32'h0200_0000 + (i << 12), 32'h0800_0000, 32'h0200_0000 + (i << 12), "R9");
        end
        for (int i = 0; i < 20; i++) idle(32'h0200_0000 + (i << 12), "R9");

        // R10 priority among simultaneous commands
        step(1, 1, 1, 1, 32'h0200_3000, 32'h3FFF_FFFF, 32'h0200_3000, "R10");
        idle(32'h0200_3000, "R10");
        step(1, 1, 1, 0, 32'h0300_0000, 32'h3FFF_FFFF, 32'h0300_0000, "R10");
        idle(32'h0300_0000, "R10");
        step(0, 1, 1, 0, 32'h0300_0000, 32'h0400_0000, 32'h0300_0000, "R10");
        idle(32'h0300_0000, "R10");
        step(0, 1, 1, 0, 32'h0310_0000, 32'h0400_0000, 32'h0300_0000, "R10");
        idle(32'h0300_0000, "R10");

        // R2 mixed random traffic over a small page pool
        for (int i = 0; i < 600; i++) begin
            automatic int c = $urandom % 16;
            automatic logic [31:0] a = 32'h0080_0000 + (($urandom % 22) << 12) + ($urandom % 4096);
            automatic logic [31:0] l = (($urandom % 8) == 0) ? 32'h0 :
                                       32'h0080_0000 + (($urandom % 22) << 12) + ($urandom % 4096);
            step(c < 5, c >= 5 && c < 11, c >= 11 && c < 14, c == 14, a, $urandom, l, "R2");
        end
        idle(32'h0, "R11");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule